// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block sits between instruction fetch and the lane datapath of a multithreaded processor core. It keeps one decoded instruction waiting for each resident warp and, every cycle, decides whether one of them may be sent to the lanes. Each decoded instruction carries a destination register, up to two source registers with their own enable bits, an opaque opcode payload and a flag for long-latency results.

Readiness comes from a pending-register table that is kept for each warp separately. Issuing an instruction marks its destination pending. A short-latency result clears its bit by itself after a fixed latency. A long-latency result clears only when its writeback arrives on the writeback input. Among the ready warps, the one that has waited longest wins. Warps with equal wait age are served in rotating order, starting after the last warp that issued. Each issue then holds the lane port for several cycles, because the instruction is broadcast to all 32 threads of the warp.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no slot holds an instruction, `issue_valid` is 0, and a fetch to any warp is accepted.
- R2: A fetch to an empty slot is accepted (`fetch_accept`=1). A fetch to a slot that still holds an unissued instruction is refused (`fetch_accept`=0), and the held instruction is the one that later issues.
- R3: At most one instruction issues per cycle. After an issue, the next issue comes no earlier than ISSUE_CYCLES (4) cycles later, and exactly then when another instruction is ready.
- R4: An instruction issues only when neither its destination nor any enabled source register is pending in its own warp. A source whose enable bit is 0 never blocks.
- R5: An issue marks the destination register pending for that warp. For a short-latency instruction (`fetch_long`=0) the bit clears by itself, so an instruction that depends on it issues SHORT_LAT (4) cycles after the producer.
- R6: A destination written by a long-latency instruction (`fetch_long`=1) stays pending until a writeback names the same warp and register. A writeback to another warp or another register does not release it.
- R7: A writeback takes effect in the same cycle for readiness. A waiting instruction whose only blocker is cleared can issue in the cycle the writeback is presented, if the port is free.
- R8: When several warps are ready, the warp whose instruction has waited the most cycles since it was fetched issues first. The wait age saturates at 2^AGE_W-1.
- R9: Ready warps with equal age are chosen in rotating order of warp index, starting at the warp after the one that issued last and wrapping at NUM_WARPS.
- R10: The issue outputs carry the warp index and the stored opcode, destination and long flag of the fetched instruction. The slot becomes free after the issue and can then be refilled.
- R11: The pending table is kept separately for each warp. The same register index pending in one warp does not block another warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch presents an instruction |
| fetch_warp | input | WID_W | Target warp slot |
| fetch_op | input | OP_W | Opcode payload |
| fetch_dst | input | REG_W | Destination register |
| fetch_src0 | input | REG_W | First source register |
| fetch_src0_en | input | 1 | First source in use |
| fetch_src1 | input | REG_W | Second source register |
| fetch_src1_en | input | 1 | Second source in use |
| fetch_long | input | 1 | Result returns through writeback |
| fetch_accept | output | 1 | Fetch taken this cycle |
| wb_valid | input | 1 | Long-latency writeback present |
| wb_warp | input | WID_W | Writeback warp |
| wb_reg | input | REG_W | Writeback register |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WID_W | Issuing warp |
| issue_op | output | OP_W | Issued opcode payload |
| issue_dst | output | REG_W | Issued destination |
| issue_src0 | output | REG_W | Issued first source |
| issue_src1 | output | REG_W | Issued second source |
| issue_long | output | 1 | Issued long flag |

## Verification
The hardest situation to reach from the ports is a tie in wait age among several ready warps, which the rotating order must then break. Ages only tie once they saturate, and only one warp can be fetched or released per cycle. The stimulus therefore parks three warps behind long-latency destinations until their ages saturate. It then issues an unrelated warp to set the rotation point and to occupy the lane port. During the busy window it releases the three warps with one writeback per cycle, so all three become ready in the same cycle and the issue order shows the rotation.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Rotating index helper: base in [0,n), step in [1,n]
  function automatic int wrap_add(input int base, input int step, input int n);
    int s;
    s = base + step;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/sched_slots.sv
module sched_slots #(
  parameter int NW    = 24,
  parameter int RW    = 4,
  parameter int OPW   = 8,
  parameter int AGE_W = 4,
  localparam int WW   = $clog2(NW)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetch_valid,
  input  logic [WW-1:0]            fetch_warp,
  input  logic [OPW-1:0]           fetch_op,
  input  logic [RW-1:0]            fetch_dst,
  input  logic [RW-1:0]            fetch_src0,
  input  logic                     fetch_src0_en,
  input  logic [RW-1:0]            fetch_src1,
  input  logic                     fetch_src1_en,
  input  logic                     fetch_long,
  output logic                     fetch_accept,
  input  logic                     issue_fire,
  input  logic [WW-1:0]            issue_warp,
  output logic [NW-1:0]            vld,
  output logic [NW-1:0][OPW-1:0]   op,
  output logic [NW-1:0][RW-1:0]    dst,
  output logic [NW-1:0][RW-1:0]    src0,
  output logic [NW-1:0]            src0_en,
  output logic [NW-1:0][RW-1:0]    src1,
  output logic [NW-1:0]            src1_en,
  output logic [NW-1:0]            lng,
  output logic [NW-1:0][AGE_W-1:0] age
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [NW-1:0]            vld_q, vld_d, load;
  logic [NW-1:0][AGE_W-1:0] age_q, age_d;

  // Next state: occupancy and wait age
  always_comb begin
    fetch_accept = fetch_valid && (int'(fetch_warp) < NW) && !vld_q[fetch_warp];
    for (int w = 0; w < NW; w++) begin
      load[w]  = fetch_accept && (int'(fetch_warp) == w);
      vld_d[w] = vld_q[w];
      age_d[w] = age_q[w];
      if (issue_fire && (int'(issue_warp) == w)) begin
        vld_d[w] = 1'b0;
        age_d[w] = '0;
      end else if (vld_q[w] && (age_q[w] != AGE_MAX)) begin
        age_d[w] = age_q[w] + 1'b1;
      end
      if (load[w]) begin
        vld_d[w] = 1'b1;
        age_d[w] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      age_q <= '0;
    end else begin
      vld_q <= vld_d;
      age_q <= age_d;
    end
  end

  // Payload storage, one enabled register set per slot
  for (genvar g = 0; g < NW; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load[g]) begin
        op[g]      <= fetch_op;
        dst[g]     <= fetch_dst;
        src0[g]    <= fetch_src0;
        src0_en[g] <= fetch_src0_en;
        src1[g]    <= fetch_src1;
        src1_en[g] <= fetch_src1_en;
        lng[g]     <= fetch_long;
      end
    end
  end

  assign vld = vld_q;
  assign age = age_q;

  // R2: an accepted fetch occupies its slot on the next cycle
  p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_accept |=> vld_q[$past(fetch_warp)]);

  // R10: an issued slot is released
  p_issue_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> !vld_q[$past(issue_warp)]);

  // R10: issue only from an occupied slot
  p_issue_from_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> vld_q[issue_warp]);

endmodule

// File: rtl/sched_scoreboard.sv
module sched_scoreboard #(
  parameter int NW  = 24,
  parameter int NR  = 16,
  parameter int LAT = 4,
  localparam int WW = $clog2(NW),
  localparam int RW = $clog2(NR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_fire,
  input  logic [WW-1:0]         issue_warp,
  input  logic [RW-1:0]         issue_dst,
  input  logic                  issue_long,
  input  logic                  wb_valid,
  input  logic [WW-1:0]         wb_warp,
  input  logic [RW-1:0]         wb_reg,
  output logic [NW-1:0][NR-1:0] pend_eff
);

  logic [NW-1:0][NR-1:0] pend_q, pend_d, clr;
  logic [LAT-1:0]          pv_q, pv_d;
  logic [LAT-1:0][WW-1:0]  pw_q, pw_d;
  logic [LAT-1:0][RW-1:0]  pr_q, pr_d;

  // Clears this cycle: external writeback and matured short results
  always_comb begin
    clr = '0;
    if (wb_valid) clr[wb_warp][wb_reg] = 1'b1;
    if (pv_q[LAT-1]) clr[pw_q[LAT-1]][pr_q[LAT-1]] = 1'b1;
    pend_eff = pend_q & ~clr;
    pend_d   = pend_eff;
    if (issue_fire) pend_d[issue_warp][issue_dst] = 1'b1;
  end

  // Fixed-latency tracker for short results
  always_comb begin
    pv_d[0] = issue_fire && !issue_long;
    pw_d[0] = issue_warp;
    pr_d[0] = issue_dst;
    for (int s = 1; s < LAT; s++) begin
      pv_d[s] = pv_q[s-1];
      pw_d[s] = pw_q[s-1];
      pr_d[s] = pr_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pv_q   <= '0;
    end else begin
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  always_ff @(posedge clk) begin
    pw_q <= pw_d;
    pr_q <= pr_d;
  end

  // R5: issue marks the destination pending
  p_set_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> pend_q[$past(issue_warp)][$past(issue_dst)]);

  // R6: a writeback releases its register unless re-claimed the same cycle
  p_wb_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(issue_fire && issue_warp == wb_warp && issue_dst == wb_reg))
      |=> !pend_q[$past(wb_warp)][$past(wb_reg)]);

endmodule

// File: rtl/sched_arbiter.sv
module sched_arbiter #(
  parameter int NW    = 24,
  parameter int AGE_W = 4,
  localparam int WW   = $clog2(NW)
) (
  input  logic [NW-1:0]            elig,
  input  logic [NW-1:0][AGE_W-1:0] age,
  input  logic [WW-1:0]            last,
  output logic                     grant_valid,
  output logic [WW-1:0]            grant_warp
);

  logic [AGE_W-1:0] best_age;

  // Scan in rotating order; a strictly older candidate replaces the pick
  always_comb begin
    grant_valid = 1'b0;
    grant_warp  = '0;
    best_age    = '0;
    for (int k = 1; k <= NW; k++) begin
      if (elig[sched_pkg::wrap_add(int'(last), k, NW)] &&
          (!grant_valid || age[sched_pkg::wrap_add(int'(last), k, NW)] > best_age)) begin
        grant_valid = 1'b1;
        grant_warp  = WW'(sched_pkg::wrap_add(int'(last), k, NW));
        best_age    = age[sched_pkg::wrap_add(int'(last), k, NW)];
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS    = 24,
  parameter int NUM_REGS     = 16,
  parameter int OP_W         = 8,
  parameter int ISSUE_CYCLES = 4,
  parameter int SHORT_LAT    = 4,
  parameter int AGE_W        = 4,
  localparam int WID_W       = $clog2(NUM_WARPS),
  localparam int REG_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [WID_W-1:0] fetch_warp,
  input  logic [OP_W-1:0]  fetch_op,
  input  logic [REG_W-1:0] fetch_dst,
  input  logic [REG_W-1:0] fetch_src0,
  input  logic             fetch_src0_en,
  input  logic [REG_W-1:0] fetch_src1,
  input  logic             fetch_src1_en,
  input  logic             fetch_long,
  output logic             fetch_accept,
  input  logic             wb_valid,
  input  logic [WID_W-1:0] wb_warp,
  input  logic [REG_W-1:0] wb_reg,
  output logic             issue_valid,
  output logic [WID_W-1:0] issue_warp,
  output logic [OP_W-1:0]  issue_op,
  output logic [REG_W-1:0] issue_dst,
  output logic [REG_W-1:0] issue_src0,
  output logic [REG_W-1:0] issue_src1,
  output logic             issue_long
);

  localparam int BUSY_W = $clog2(ISSUE_CYCLES + 1);

  logic [NUM_WARPS-1:0]                vld, s0en, s1en, lng, elig;
  logic [NUM_WARPS-1:0][OP_W-1:0]      op;
  logic [NUM_WARPS-1:0][REG_W-1:0]     dst, src0, src1;
  logic [NUM_WARPS-1:0][AGE_W-1:0]     age;
  logic [NUM_WARPS-1:0][NUM_REGS-1:0]  pend;
  logic                                grant_valid, issue_fire, port_free;
  logic [WID_W-1:0]                    grant_warp, last_q, last_d;
  logic [BUSY_W-1:0]                   busy_q, busy_d;

  sched_slots #(.NW(NUM_WARPS), .RW(REG_W), .OPW(OP_W), .AGE_W(AGE_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_op(fetch_op),
    .fetch_dst(fetch_dst), .fetch_src0(fetch_src0), .fetch_src0_en(fetch_src0_en),
    .fetch_src1(fetch_src1), .fetch_src1_en(fetch_src1_en), .fetch_long(fetch_long),
    .fetch_accept(fetch_accept),
    .issue_fire(issue_fire), .issue_warp(grant_warp),
    .vld(vld), .op(op), .dst(dst), .src0(src0), .src0_en(s0en),
    .src1(src1), .src1_en(s1en), .lng(lng), .age(age)
  );

  sched_scoreboard #(.NW(NUM_WARPS), .NR(NUM_REGS), .LAT(SHORT_LAT)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .issue_fire(issue_fire), .issue_warp(grant_warp),
    .issue_dst(dst[grant_warp]), .issue_long(lng[grant_warp]),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .pend_eff(pend)
  );

  // Per-warp readiness against its own pending table
  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_ready
    assign elig[g] = vld[g] && !pend[g][dst[g]]
                     && !(s0en[g] && pend[g][src0[g]])
                     && !(s1en[g] && pend[g][src1[g]]);
  end

  sched_arbiter #(.NW(NUM_WARPS), .AGE_W(AGE_W)) u_arb (
    .elig(elig), .age(age), .last(last_q),
    .grant_valid(grant_valid), .grant_warp(grant_warp)
  );

  // Lane port occupancy and rotation point
  always_comb begin
    port_free  = (busy_q == '0);
    issue_fire = grant_valid && port_free;
    busy_d     = busy_q;
    last_d     = last_q;
    if (issue_fire) begin
      busy_d = BUSY_W'(ISSUE_CYCLES - 1);
      last_d = grant_warp;
    end else if (busy_q != '0) begin
      busy_d = busy_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      last_q <= WID_W'(NUM_WARPS - 1);
    end else begin
      busy_q <= busy_d;
      last_q <= last_d;
    end
  end

  assign issue_valid = issue_fire;
  assign issue_warp  = grant_warp;
  assign issue_op    = op[grant_warp];
  assign issue_dst   = dst[grant_warp];
  assign issue_src0  = src0[grant_warp];
  assign issue_src1  = src1[grant_warp];
  assign issue_long  = lng[grant_warp];

  // R3: no two issues in consecutive cycles
  p_issue_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !issue_valid);

  // R8: the arbiter only grants a ready warp
  p_grant_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> elig[grant_warp]);

endmodule

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       fetch_valid, fetch_src0_en, fetch_src1_en, fetch_long, fetch_accept;
  logic [4:0] fetch_warp, wb_warp, issue_warp;
  logic [7:0] fetch_op, issue_op;
  logic [3:0] fetch_dst, fetch_src0, fetch_src1, wb_reg;
  logic [3:0] issue_dst, issue_src0, issue_src1;
  logic       wb_valid, issue_valid, issue_long;

  warp_issue_sched dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_op(fetch_op),
    .fetch_dst(fetch_dst), .fetch_src0(fetch_src0), .fetch_src0_en(fetch_src0_en),
    .fetch_src1(fetch_src1), .fetch_src1_en(fetch_src1_en), .fetch_long(fetch_long),
    .fetch_accept(fetch_accept),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_op(issue_op),
    .issue_dst(issue_dst), .issue_src0(issue_src0), .issue_src1(issue_src1),
    .issue_long(issue_long)
  );

  typedef struct { int w; int op; int dst; bit lng; } exp_t;
  exp_t expq[$];
  int   issue_cyc [256];
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  int   wb_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expect_issue(input int w, input int op, input int dst, input bit lng);
    exp_t e;
    e.w = w; e.op = op; e.dst = dst; e.lng = lng;
    expq.push_back(e);
  endtask

  // Monitor: compare each issue against the expected queue
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n === 1'b1 && issue_valid === 1'b1) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected issue warp=%0d op=%0d expected none", issue_warp, issue_op);
        end else begin
          e = expq.pop_front();
          if (int'(issue_warp) != e.w || int'(issue_op) != e.op ||
              int'(issue_dst) != e.dst || issue_long != e.lng) begin
            errors++;
            $display("FAIL R10 issue warp=%0d op=%0d dst=%0d long=%0d expected warp=%0d op=%0d dst=%0d long=%0d",
                     issue_warp, issue_op, issue_dst, issue_long, e.w, e.op, e.dst, e.lng);
          end
        end
        issue_cyc[issue_op] = cyc;
      end
    end
  end

  task automatic fetch(input int w, input int op, input int dst, input int s0, input bit u0,
                       input int s1, input bit u1, input bit lng, input bit acc);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_warp = 5'(w); fetch_op = 8'(op); fetch_dst = 4'(dst);
    fetch_src0 = 4'(s0); fetch_src0_en = u0; fetch_src1 = 4'(s1); fetch_src1_en = u1;
    fetch_long = lng;
    #1;
    chk(fetch_accept === acc, "R2 fetch_accept", int'(fetch_accept), int'(acc));
    @(posedge clk);
    #1 fetch_valid = 1'b0;
  endtask

  task automatic wb(input int w, input int r);
    @(negedge clk);
    wb_valid = 1'b1; wb_warp = 5'(w); wb_reg = 4'(r);
    wb_cyc = cyc;
    @(posedge clk);
    #1 wb_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_issue(input int op, input int maxc, input string req);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      #3;
      if (issue_cyc[op] != -1) return;
    end
    chk(1'b0, req, -1, op);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) issue_cyc[i] = -1;
    rst_n = 1'b0;
    fetch_valid = 1'b0; fetch_warp = '0; fetch_op = '0; fetch_dst = '0;
    fetch_src0 = '0; fetch_src0_en = 1'b0; fetch_src1 = '0; fetch_src1_en = 1'b0;
    fetch_long = 1'b0; wb_valid = 1'b0; wb_warp = '0; wb_reg = '0;
    idle(3);
    rst_n = 1'b1;
    #1;
    chk(issue_valid === 1'b0, "R1 no issue after reset", int'(issue_valid), 0);
    idle(2);

    // R1/R2/R10: basic fill, issue, refill of the same slot
    expect_issue(0, 1, 1, 0);
    fetch(0, 1, 1, 0, 0, 0, 0, 0, 1);
    wait_issue(1, 10, "R10 first issue");
    expect_issue(0, 2, 2, 0);
    fetch(0, 2, 2, 0, 0, 0, 0, 0, 1);
    wait_issue(2, 10, "R10 refilled slot");
    idle(8);

    // R5: dependent on a short result issues SHORT_LAT later
    expect_issue(3, 5, 7, 0);
    fetch(3, 5, 7, 0, 0, 0, 0, 0, 1);
    wait_issue(5, 10, "R5 producer");
    expect_issue(3, 6, 8, 0);
    fetch(3, 6, 8, 7, 1, 0, 0, 0, 1);
    wait_issue(6, 20, "R5 consumer");
    chk(issue_cyc[6] - issue_cyc[5] == 4, "R5 short latency gap",
        issue_cyc[6] - issue_cyc[5], 4);
    idle(8);

    // R3: independent warps issue every ISSUE_CYCLES
    expect_issue(4, 7, 1, 0);
    expect_issue(5, 8, 1, 0);
    expect_issue(6, 9, 1, 0);
    fetch(4, 7, 1, 0, 0, 0, 0, 0, 1);
    fetch(5, 8, 1, 0, 0, 0, 0, 0, 1);
    fetch(6, 9, 1, 0, 0, 0, 0, 0, 1);
    wait_issue(9, 30, "R3 third issue");
    chk(issue_cyc[8] - issue_cyc[7] == 4, "R3 spacing a", issue_cyc[8] - issue_cyc[7], 4);
    chk(issue_cyc[9] - issue_cyc[8] == 4, "R3 spacing b", issue_cyc[9] - issue_cyc[8], 4);
    idle(8);

    // R8: oldest ready warp wins over rotating order
    expect_issue(8, 10, 2, 0);
    expect_issue(11, 11, 2, 0);
    expect_issue(10, 12, 2, 0);
    expect_issue(9, 13, 2, 0);
    fetch(8, 10, 2, 0, 0, 0, 0, 0, 1);
    fetch(11, 11, 2, 0, 0, 0, 0, 0, 1);
    fetch(10, 12, 2, 0, 0, 0, 0, 0, 1);
    fetch(9, 13, 2, 0, 0, 0, 0, 0, 1);
    wait_issue(13, 40, "R8 last of age group");
    chk(issue_cyc[11] < issue_cyc[13], "R8 oldest before newest", issue_cyc[11], issue_cyc[13]);
    idle(8);

    // R6/R7/R11/R2: long result, refused fetch, same-cycle writeback
    expect_issue(1, 14, 5, 1);
    fetch(1, 14, 5, 0, 0, 0, 0, 1, 1);
    wait_issue(14, 10, "R6 long producer");
    fetch(1, 15, 6, 5, 1, 0, 0, 0, 1);
    fetch(1, 16, 9, 0, 0, 0, 0, 0, 0);
    idle(10);
    chk(issue_cyc[15] == -1, "R6 waits for writeback", issue_cyc[15], -1);
    wb(2, 5);
    wb(1, 6);
    idle(6);
    chk(issue_cyc[15] == -1, "R11 other warp writeback ignored", issue_cyc[15], -1);
    expect_issue(1, 15, 6, 0);
    wb(1, 5);
    wait_issue(15, 10, "R7 released");
    chk(issue_cyc[15] == wb_cyc, "R7 same-cycle writeback", issue_cyc[15], wb_cyc);
    idle(10);
    chk(issue_cyc[16] == -1, "R2 refused fetch never issues", issue_cyc[16], -1);

    // R4: disabled source ignored, destination hazard blocks
    expect_issue(16, 20, 3, 1);
    fetch(16, 20, 3, 0, 0, 0, 0, 1, 1);
    wait_issue(20, 10, "R4 producer");
    expect_issue(16, 21, 4, 0);
    fetch(16, 21, 4, 3, 0, 3, 0, 0, 1);
    wait_issue(21, 10, "R4 disabled source ignored");
    fetch(16, 22, 3, 0, 0, 0, 0, 0, 1);
    idle(12);
    chk(issue_cyc[22] == -1, "R4 destination hazard", issue_cyc[22], -1);
    expect_issue(16, 22, 3, 0);
    wb(16, 3);
    wait_issue(22, 10, "R4 after release");
    idle(8);

    // R9: saturated ages tie, rotation starts after the last issuer
    expect_issue(12, 30, 9, 1);
    expect_issue(14, 31, 9, 1);
    expect_issue(20, 32, 9, 1);
    fetch(12, 30, 9, 0, 0, 0, 0, 1, 1);
    fetch(14, 31, 9, 0, 0, 0, 0, 1, 1);
    fetch(20, 32, 9, 0, 0, 0, 0, 1, 1);
    wait_issue(32, 30, "R9 setup");
    fetch(12, 33, 10, 9, 1, 0, 0, 0, 1);
    fetch(14, 34, 10, 9, 1, 0, 0, 0, 1);
    fetch(20, 35, 10, 9, 1, 0, 0, 0, 1);
    idle(30);
    chk(issue_cyc[33] == -1 && issue_cyc[34] == -1 && issue_cyc[35] == -1,
        "R6 parked warps held", issue_cyc[33], -1);
    expect_issue(13, 36, 11, 0);
    expect_issue(14, 34, 10, 0);
    expect_issue(20, 35, 10, 0);
    expect_issue(12, 33, 10, 0);
    fetch(13, 36, 11, 0, 0, 0, 0, 0, 1);
    wait_issue(36, 10, "R9 rotation setter");
    wb(20, 9);
    wb(12, 9);
    wb(14, 9);
    wait_issue(33, 30, "R9 tie group");
    chk(issue_cyc[34] - issue_cyc[36] == 4, "R9 first of tie group", issue_cyc[34] - issue_cyc[36], 4);

    idle(10);
    chk(expq.size() == 0, "R10 all expected issues seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule